// File: doc/BRIEF.md
# Interrupt Level-Change Message Generator

This block gathers a vector of interrupt status bits, each gated by its own enable bit, into one active-high request level. Interrupt status is thereby delivered as discrete events on a message port rather than as a wire level. The emulated legacy interrupt pin is active low, so a rising request stands for a falling pin edge and a falling request stands for a rising pin edge.

In legacy mode, each change of the combined request queues one message on a valid/ready port. A rise queues an assert code and a fall queues a deassert code. While the port is stalled, the queued message is held. If the request flips back before the message is taken, the queued message is dropped, so the receiver never sees a redundant assert/deassert pair. In message-signalled mode, one shared pulse is raised only when the combined request rises. A fall produces nothing in that mode.

The stored request level is a register compared against the live combined value on every clock. Reset clears it and sends nothing. The mode select is meant to be changed while the request is low.

Top module: `irq_msg_gen`

## Requirements
- R1: The request is the OR over all sources of (status AND enable). In legacy mode (`msi_mode`=0), a false-to-true change seen at a clock edge makes `msg_valid`=1 with `msg_type`=2'b01 (assert) right after that same edge.
- R2: In legacy mode, a true-to-false change of the request makes `msg_valid`=1 with `msg_type`=2'b10 (deassert) right after the edge that sees it.
- R3: A source whose enable bit is 0 never contributes to the request. Clearing the enable of the only active source lowers the request and yields a deassert message.
- R4: While `msg_valid`=1 and `msg_ready`=0, and the request does not change, `msg_valid` stays 1 and `msg_type` stays unchanged.
- R5: If the request changes while a message is queued and not accepted in that cycle, the queued message is dropped and `msg_valid` is 0 after the edge. No message is sent for either change.
- R6: A message is accepted at an edge where `msg_valid` and `msg_ready` are both 1. After that edge `msg_valid` is 0, unless the request changed at the same edge, in which case the new message is loaded.
- R7: In message-signalled mode (`msi_mode`=1), a rise of the request makes `msi_req` 1 for exactly one cycle after the edge that sees it. A fall produces no pulse, and no legacy message is produced in this mode.
- R8: While `rst_n`=0, `msg_valid` and `msi_req` are 0 and the stored request level is cleared. Leaving reset with the request low sends nothing. Leaving reset with the request high sends an assert at the first edge.
- R9: `msg_type` is 2'b00 whenever `msg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_status | input | NUM_SRC | Per-source interrupt status |
| irq_enable | input | NUM_SRC | Per-source enable; 0 masks the source |
| msi_mode | input | 1 | 0 = legacy messages, 1 = message-signalled pulse |
| msg_ready | input | 1 | Message port can accept |
| msg_valid | output | 1 | A message is offered |
| msg_type | output | 2 | 01 assert, 10 deassert, 00 idle |
| msi_req | output | 1 | One-cycle message-signalled request |

## Verification
A stored request level that disagrees with the live masked OR shows up one edge later as a spurious or missing message, and an assert or deassert whose code contradicts the level. A queued message that is lost, or is not dropped when the request reverses, is visible within a single cycle as `msg_valid` disagreeing with the expected ready/edge history. A wrong pulse in message-signalled mode shows immediately after the edge as a pulse that lasts two cycles or one that appears on a falling request.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  typedef enum logic [1:0] {
    MSG_IDLE     = 2'b00,
    MSG_ASSERT   = 2'b01,
    MSG_DEASSERT = 2'b10
  } msg_code_e;
endpackage

// File: rtl/irq_req_combine.sv
module irq_req_combine #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] enable_i,
  output logic               req_o
);
  logic [NUM_SRC-1:0] gated;

  function automatic logic any_set(input logic [NUM_SRC-1:0] v);
    return |v;
  endfunction

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    assign gated[g] = status_i[g] & enable_i[g];
  end

  assign req_o = any_set(gated);
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= req_i;
  end

  assign level_o = level_q;
  assign rise_o  = req_i & ~level_q;
  assign fall_o  = ~req_i & level_q;
endmodule

// File: rtl/irq_msg_slot.sv
module irq_msg_slot
  import irq_msg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_assert_i,
  input  logic      load_deassert_i,
  input  logic      ready_i,
  output logic      valid_o,
  output msg_code_e code_o,
  output logic      cancel_o
);
  logic      valid_q;
  msg_code_e code_q;
  logic      accept;
  logic      load;

  assign accept   = valid_q & ready_i;
  assign load     = load_assert_i | load_deassert_i;
  assign cancel_o = load & valid_q & ~accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= MSG_IDLE;
    end else if (cancel_o) begin
      valid_q <= 1'b0;
      code_q  <= MSG_IDLE;
    end else if (load) begin
      valid_q <= 1'b1;
      code_q  <= load_assert_i ? MSG_ASSERT : MSG_DEASSERT;
    end else if (accept) begin
      valid_q <= 1'b0;
      code_q  <= MSG_IDLE;
    end
  end

  assign valid_o = valid_q;
  assign code_o  = code_q;
endmodule

// File: rtl/irq_msi_pulse.sv
module irq_msi_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic enable_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= rise_i & enable_i;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
  import irq_msg_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_status,
  input  logic [NUM_SRC-1:0] irq_enable,
  input  logic               msi_mode,
  input  logic               msg_ready,
  output logic               msg_valid,
  output logic [1:0]         msg_type,
  output logic               msi_req
);
  logic      req_now;
  logic      req_level;
  logic      req_rise;
  logic      req_fall;
  logic      legacy_edge;
  logic      cancel_evt;
  msg_code_e slot_code;

  irq_req_combine #(.NUM_SRC(NUM_SRC)) u_combine (
    .status_i (irq_status),
    .enable_i (irq_enable),
    .req_o    (req_now)
  );

  irq_level_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_now),
    .level_o (req_level),
    .rise_o  (req_rise),
    .fall_o  (req_fall)
  );

  assign legacy_edge = (req_rise | req_fall) & ~msi_mode;

  irq_msg_slot u_slot (
    .clk             (clk),
    .rst_n           (rst_n),
    .load_assert_i   (req_rise & ~msi_mode),
    .load_deassert_i (req_fall & ~msi_mode),
    .ready_i         (msg_ready),
    .valid_o         (msg_valid),
    .code_o          (slot_code),
    .cancel_o        (cancel_evt)
  );

  assign msg_type = slot_code;

  irq_msi_pulse u_msi (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (req_rise),
    .enable_i (msi_mode),
    .pulse_o  (msi_req)
  );
endmodule

// File: rtl/irq_msg_gen_chk.sv
module irq_msg_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       msi_mode,
  input logic       msg_ready,
  input logic       msg_valid,
  input logic [1:0] msg_type,
  input logic       msi_req,
  input logic       req_level,
  input logic       legacy_edge,
  input logic       cancel_evt
);
  assert_assert_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 2'b01) |-> req_level);

  assert_deassert_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 2'b10) |-> !req_level);

  assert_hold_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && !legacy_edge) |=> (msg_valid && $stable(msg_type)));

  assert_cancel_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> !msg_valid);

  assert_msi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);

  assert_msi_on_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> req_level);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |-> (!msg_valid && !msi_req));

  assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> (msg_type == 2'b00));
endmodule

bind irq_msg_gen irq_msg_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msi_mode    (msi_mode),
  .msg_ready   (msg_ready),
  .msg_valid   (msg_valid),
  .msg_type    (msg_type),
  .msi_req     (msi_req),
  .req_level   (req_level),
  .legacy_edge (legacy_edge),
  .cancel_evt  (cancel_evt)
);

// File: tb/irq_msg_gen_bench.sv
module irq_msg_gen_bench;
  localparam int N = 8;

  typedef struct packed {
    logic       mode;
    logic       rdy;
    logic [7:0] st;
    logic [7:0] en;
    logic       v;
    logic [1:0] t;
    logic       m;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    {1'b0,1'b1,8'h00,8'hFF,1'b0,2'b00,1'b0},  // 0 idle
    {1'b0,1'b1,8'h01,8'hFF,1'b1,2'b01,1'b0},  // 1 R1 rise -> assert
    {1'b0,1'b1,8'h01,8'hFF,1'b0,2'b00,1'b0},  // 2 R6 accepted
    {1'b0,1'b1,8'h03,8'hFF,1'b0,2'b00,1'b0},  // 3 R1 still high
    {1'b0,1'b1,8'h02,8'hFE,1'b0,2'b00,1'b0},  // 4 R3 other source holds
    {1'b0,1'b1,8'h02,8'hFD,1'b1,2'b10,1'b0},  // 5 R3 mask -> deassert
    {1'b0,1'b1,8'h02,8'hFD,1'b0,2'b00,1'b0},  // 6 R6
    {1'b0,1'b0,8'h80,8'hFD,1'b1,2'b01,1'b0},  // 7 R1 rise, stalled
    {1'b0,1'b0,8'h80,8'hFD,1'b1,2'b01,1'b0},  // 8 R4 held
    {1'b0,1'b0,8'h00,8'hFD,1'b0,2'b00,1'b0},  // 9 R5 cancel
    {1'b0,1'b1,8'h00,8'hFD,1'b0,2'b00,1'b0},  // 10 R5 nothing sent
    {1'b0,1'b1,8'h10,8'h00,1'b0,2'b00,1'b0},  // 11 R3 masked source
    {1'b0,1'b1,8'h10,8'h10,1'b1,2'b01,1'b0},  // 12 R1
    {1'b0,1'b1,8'h10,8'h10,1'b0,2'b00,1'b0},  // 13 R6
    {1'b1,1'b1,8'h00,8'h10,1'b0,2'b00,1'b0},  // 14 R7 fall: nothing
    {1'b1,1'b1,8'h04,8'hFF,1'b0,2'b00,1'b1},  // 15 R7 pulse
    {1'b1,1'b1,8'h04,8'hFF,1'b0,2'b00,1'b0},  // 16 R7 one cycle
    {1'b1,1'b1,8'h00,8'hFF,1'b0,2'b00,1'b0},  // 17 R7
    {1'b1,1'b1,8'h04,8'hFF,1'b0,2'b00,1'b1},  // 18 R7 again
    {1'b1,1'b1,8'h00,8'hFF,1'b0,2'b00,1'b0},  // 19 R7
    {1'b0,1'b1,8'h00,8'hFF,1'b0,2'b00,1'b0},  // 20 R9
    {1'b0,1'b0,8'h01,8'hFF,1'b1,2'b01,1'b0},  // 21 R1 stalled
    {1'b0,1'b1,8'h00,8'hFF,1'b1,2'b10,1'b0},  // 22 R6 accept + new edge
    {1'b0,1'b1,8'h00,8'hFF,1'b0,2'b00,1'b0}   // 23 R6
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_status = '0;
  logic [N-1:0] irq_enable = '0;
  logic         msi_mode = 1'b0;
  logic         msg_ready = 1'b0;
  logic         msg_valid;
  logic [1:0]   msg_type;
  logic         msi_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_msg_gen #(.NUM_SRC(N)) u_irq_msg_gen (
    .clk(clk), .rst_n(rst_n), .irq_status(irq_status), .irq_enable(irq_enable),
    .msi_mode(msi_mode), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_type(msg_type), .msi_req(msi_req)
  );

  task automatic check(input string req, input logic v, input logic [1:0] t, input logic m);
    n_run++;
    if (msg_valid !== v || msg_type !== t || msi_req !== m) begin
      n_fail++;
      $display("FAIL %s: got v=%b t=%b m=%b expected v=%b t=%b m=%b",
               req, msg_valid, msg_type, msi_req, v, t, m);
    end
  endtask

  task automatic step(input logic mode, input logic rdy, input logic [7:0] st, input logic [7:0] en);
    @(negedge clk);
    msi_mode = mode; msg_ready = rdy; irq_status = st; irq_enable = en;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset", 1'b0, 2'b00, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].mode, TBL[i].rdy, TBL[i].st, TBL[i].en);
      check($sformatf("table row %0d (R1..R9 per row note)", i), TBL[i].v, TBL[i].t, TBL[i].m);
    end

    // R8: reset with a pending message and request high; leave reset with request low
    step(1'b0, 1'b0, 8'h20, 8'hFF);
    check("R1 pre-reset", 1'b1, 2'b01, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R8 in reset", 1'b0, 2'b00, 1'b0);
    irq_status = 8'h00;
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b1, 8'h00, 8'hFF);
    check("R8 quiet release", 1'b0, 2'b00, 1'b0);

    // R8: leave reset with request high -> assert at first edge
    @(negedge clk); rst_n = 1'b0; irq_status = 8'h40;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 high release", 1'b1, 2'b01, 1'b0);
    step(1'b0, 1'b1, 8'h40, 8'hFF);
    check("R6 accept", 1'b0, 2'b00, 1'b0);

    // R3: masked source toggling has no effect
    step(1'b0, 1'b1, 8'h41, 8'hFE);
    check("R3 masked rise", 1'b0, 2'b00, 1'b0);
    step(1'b0, 1'b1, 8'h00, 8'hFF);
    check("R2 fall", 1'b1, 2'b10, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule